// File: doc/BRIEF.md
# Byte-Oriented ALU Execute Unit

This unit is the execute stage of an 8-bit accumulator-style microcontroller core. Each cycle that `issue` is high it takes a 16-bit instruction word, the operand read from the file register, the working register value and the current carry flag. It decodes the byte-oriented file-register operations, computes the 8-bit result, and registers the result together with write enables for the file register and the working register, a mask of the status flags the instruction updates, and the new values of those flags.

The upper instruction byte selects the operation. Its lowest bit is either a destination bit (`d`) or a "file only" bit (`s`), depending on the operation. The lower byte is a file address and this unit ignores it. Instruction fetch, skips, the register file and the multiplier live elsewhere. The surrounding core applies `flag_upd` and `flag_val` to its status register, and it uses `file_we` and `wreg_we` to commit `result`.

A two-state control machine tracks output validity. `ST_IDLE` means the outputs carry no operation. `ST_VALID` means they hold the operation issued on the previous edge. The transition `T_ISSUE` (IDLE to VALID) and the loop `T_STREAM` (VALID to VALID) are both taken when `issue` is high. The transition `T_DRAIN` (VALID to IDLE) and the loop `T_REST` (IDLE to IDLE) are both taken when `issue` is low.

Top module: `exu_top`

## Requirements
- R1: `issue` is sampled on the rising clock edge. All outputs come from registers, and `res_valid` is high in exactly the cycle that follows an edge where `issue` was high.
- R2: After an edge where `issue` was low, and out of reset, `file_we`, `wreg_we`, `flag_upd` and `flag_val` are all zero.
- R3: The flag vectors use bit 0 = C, bit 1 = DC, bit 2 = Z and bit 3 = OV. A `flag_val` bit whose `flag_upd` bit is 0 reads 0. Whenever Z is updated, Z is 1 exactly when `result` is 0x00.
- R4: The upper byte is written as seven opcode bits followed by the d or s bit. Add (0000_111d) gives f+W. Add-with-carry (0001_000d) gives f+W+C. Increment (0001_010d) gives f+1. Each updates all four flags: C is the carry out of bit 7, DC is the carry out of bit 3, and OV is the signed overflow.
- R5: Subtract (0000_010d) computes f+~W+1. Subtract-with-borrow (0000_001d) computes f+~W+C. Decrement (0000_011d) computes f+0xFE+1. Negate (0010_110s) computes 0+~W+1. Each updates all four flags from that sum, so C=1 means no borrow.
- R6: AND (0000_101d), inclusive OR (0000_100d) and complement of f (0001_001d) update only Z.
- R7: Rotate-left through carry (0001_101d) gives {f[6:0],C} and sets C=f[7]. Rotate-right through carry (0001_100d) gives {C,f[7:1]} and sets C=f[0]. Both update only C. Rotate-left (0010_001d) and rotate-right (0010_000d) without carry recirculate the end bit and update no flags.
- R8: Nibble swap (0001_110d) gives {f[3:0],f[7:4]}. Set (0010_101s) gives 0xFF. Clear (0010_100s) gives 0x00. None of them updates flags.
- R9: Decimal adjust (0010_111s) works on W. First t = W + 6 when W[3:0] > 9, otherwise t = W (t is 9 bits wide). Then h = C | t[8] | (t[7:4] > 9). The result is t[7:0] + (h ? 0x60 : 0), and the only flag update is C = h.
- R10: For operations with a d bit (instr[8]), 1 writes only the file register and 0 writes only W. For negate, set, clear and decimal adjust, the same bit is an s bit: 1 writes only the file register and 0 writes both.
- R11: Upper byte 0x01 moves W: result = W, file write only, no flags. Every other upper byte not listed in R4–R10, including 0x00 (the all-zero no-op), gives no write enables, no flag updates and a result of 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An instruction is presented this cycle |
| instr | input | 16 | Instruction word |
| fval | input | 8 | File register operand |
| wval | input | 8 | Working register value |
| c_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Registered outputs hold an issued operation |
| result | output | 8 | Operation result |
| file_we | output | 1 | Write result to the file register |
| wreg_we | output | 1 | Write result to the working register |
| flag_upd | output | 4 | Flags updated: {OV,Z,DC,C} |
| flag_val | output | 4 | New flag values: {OV,Z,DC,C} |

## Verification
The assertions check the following on every cycle:
- `res_valid` follows `issue` one cycle later.
- The enables and flag outputs are quiet when nothing was issued.
- Flag bits that are not updated read zero.
- An updated Z agrees with the result.
- An OV update always comes with the full arithmetic flag set.
- Set always yields 0xFF and updates no flags.

Only the bench's sweeps show the rest: the arithmetic results, the carry, half-carry and overflow values, the rotate and decimal-adjust behaviour, the d/s routing per operation, and that all 219 unused upper bytes are silent.

// File: rtl/exu_pkg.sv
package exu_pkg;
    localparam int EXU_DW   = 8;
    localparam int EXU_IW   = 2 * EXU_DW;
    localparam int EXU_NFLG = 4;

    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_OV = 3;

    localparam logic [EXU_NFLG-1:0] UPD_NONE = 4'b0000;
    localparam logic [EXU_NFLG-1:0] UPD_C    = 4'b0001;
    localparam logic [EXU_NFLG-1:0] UPD_Z    = 4'b0100;
    localparam logic [EXU_NFLG-1:0] UPD_ALL  = 4'b1111;

    typedef enum logic [4:0] {
        OP_NONE, OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_AND, OP_IOR, OP_COM,
        OP_INC, OP_DEC, OP_NEG, OP_RLC, OP_RRC, OP_RLN, OP_RRN, OP_SWAP,
        OP_SET, OP_CLR, OP_DAW, OP_MOVW
    } exu_op_e;

    typedef enum logic [1:0] {DST_NONE, DST_FILE, DST_WREG, DST_BOTH} exu_dst_e;

    typedef struct packed {
        exu_op_e               op;
        exu_dst_e              dst;
        logic [EXU_NFLG-1:0]   upd;
    } exu_ctl_t;

    typedef enum logic [0:0] {ST_IDLE, ST_VALID} exu_state_e;
endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [EXU_DW-1:0] opc,
    output exu_ctl_t          ctl
);
    logic sel_bit;
    logic s_type;

    assign sel_bit = opc[0];

    always_comb begin
        ctl.op  = OP_NONE;
        ctl.upd = UPD_NONE;
        s_type  = 1'b0;
        case (opc[7:1])
            7'b0000111: begin ctl.op = OP_ADD;  ctl.upd = UPD_ALL; end
            7'b0001000: begin ctl.op = OP_ADDC; ctl.upd = UPD_ALL; end
            7'b0000010: begin ctl.op = OP_SUB;  ctl.upd = UPD_ALL; end
            7'b0000001: begin ctl.op = OP_SUBB; ctl.upd = UPD_ALL; end
            7'b0001010: begin ctl.op = OP_INC;  ctl.upd = UPD_ALL; end
            7'b0000011: begin ctl.op = OP_DEC;  ctl.upd = UPD_ALL; end
            7'b0010110: begin ctl.op = OP_NEG;  ctl.upd = UPD_ALL; s_type = 1'b1; end
            7'b0000101: begin ctl.op = OP_AND;  ctl.upd = UPD_Z; end
            7'b0000100: begin ctl.op = OP_IOR;  ctl.upd = UPD_Z; end
            7'b0001001: begin ctl.op = OP_COM;  ctl.upd = UPD_Z; end
            7'b0001101: begin ctl.op = OP_RLC;  ctl.upd = UPD_C; end
            7'b0001100: begin ctl.op = OP_RRC;  ctl.upd = UPD_C; end
            7'b0010001: ctl.op = OP_RLN;
            7'b0010000: ctl.op = OP_RRN;
            7'b0001110: ctl.op = OP_SWAP;
            7'b0010101: begin ctl.op = OP_SET; s_type = 1'b1; end
            7'b0010100: begin ctl.op = OP_CLR; s_type = 1'b1; end
            7'b0010111: begin ctl.op = OP_DAW; ctl.upd = UPD_C; s_type = 1'b1; end
            7'b0000000: if (sel_bit) ctl.op = OP_MOVW;
            default: ;
        endcase
    end

    always_comb begin
        if (ctl.op == OP_NONE)      ctl.dst = DST_NONE;
        else if (ctl.op == OP_MOVW) ctl.dst = DST_FILE;
        else if (s_type)            ctl.dst = sel_bit ? DST_FILE : DST_BOTH;
        else                        ctl.dst = sel_bit ? DST_FILE : DST_WREG;
    end
endmodule

// File: rtl/exu_datapath.sv
module exu_datapath
    import exu_pkg::*;
(
    input  exu_op_e             op,
    input  logic [EXU_DW-1:0]   f,
    input  logic [EXU_DW-1:0]   w,
    input  logic                c,
    output logic [EXU_DW-1:0]   res,
    output logic [EXU_NFLG-1:0] fl
);
    localparam int HN = EXU_DW / 2;

    logic [EXU_DW-1:0] add_a, add_b;
    logic              add_ci;
    logic [EXU_DW:0]   sum;
    logic [HN:0]       nib;
    logic              ovf;
    logic              daw_lo, daw_hi;
    logic [EXU_DW:0]   daw_t;
    logic [EXU_DW-1:0] daw_r;
    logic              cy;

    always_comb begin
        add_a  = f;
        add_b  = w;
        add_ci = 1'b0;
        case (op)
            OP_ADDC: add_ci = c;
            OP_SUB:  begin add_b = ~w; add_ci = 1'b1; end
            OP_SUBB: begin add_b = ~w; add_ci = c; end
            OP_INC:  begin add_b = '0; add_ci = 1'b1; end
            OP_DEC:  begin add_b = 8'hFE; add_ci = 1'b1; end
            OP_NEG:  begin add_a = '0; add_b = ~w; add_ci = 1'b1; end
            default: ;
        endcase
    end

    assign sum = {1'b0, add_a} + {1'b0, add_b} + {{EXU_DW{1'b0}}, add_ci};
    assign nib = {1'b0, add_a[HN-1:0]} + {1'b0, add_b[HN-1:0]} + {{HN{1'b0}}, add_ci};
    assign ovf = (add_a[EXU_DW-1] == add_b[EXU_DW-1]) && (sum[EXU_DW-1] != add_a[EXU_DW-1]);

    assign daw_lo = w[HN-1:0] > 4'd9;
    assign daw_t  = {1'b0, w} + (daw_lo ? 9'd6 : 9'd0);
    assign daw_hi = c | daw_t[EXU_DW] | (daw_t[EXU_DW-1:HN] > 4'd9);
    assign daw_r  = daw_t[EXU_DW-1:0] + (daw_hi ? 8'h60 : 8'h00);

    always_comb begin
        res = '0;
        cy  = sum[EXU_DW];
        case (op)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB,
            OP_INC, OP_DEC, OP_NEG:  res = sum[EXU_DW-1:0];
            OP_AND:  res = f & w;
            OP_IOR:  res = f | w;
            OP_COM:  res = ~f;
            OP_RLC:  begin res = {f[EXU_DW-2:0], c}; cy = f[EXU_DW-1]; end
            OP_RRC:  begin res = {c, f[EXU_DW-1:1]}; cy = f[0]; end
            OP_RLN:  res = {f[EXU_DW-2:0], f[EXU_DW-1]};
            OP_RRN:  res = {f[0], f[EXU_DW-1:1]};
            OP_SWAP: res = {f[HN-1:0], f[EXU_DW-1:HN]};
            OP_SET:  res = '1;
            OP_CLR:  res = '0;
            OP_DAW:  begin res = daw_r; cy = daw_hi; end
            OP_MOVW: res = w;
            default: res = '0;
        endcase
    end

    always_comb begin
        fl         = '0;
        fl[FLG_C]  = cy;
        fl[FLG_DC] = nib[HN];
        fl[FLG_Z]  = (res == '0);
        fl[FLG_OV] = ovf;
    end
endmodule

// File: rtl/exu_top.sv
module exu_top
    import exu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue,
    input  logic [15:0] instr,
    input  logic [7:0]  fval,
    input  logic [7:0]  wval,
    input  logic        c_in,
    output logic        res_valid,
    output logic [7:0]  result,
    output logic        file_we,
    output logic        wreg_we,
    output logic [3:0]  flag_upd,
    output logic [3:0]  flag_val
);
    exu_ctl_t            ctl;
    logic [EXU_DW-1:0]   dp_res;
    logic [EXU_NFLG-1:0] dp_fl;
    exu_state_e          state_q, state_d;

    exu_decode u_dec (
        .opc (instr[EXU_IW-1:EXU_DW]),
        .ctl (ctl)
    );

    exu_datapath u_dp (
        .op  (ctl.op),
        .f   (fval),
        .w   (wval),
        .c   (c_in),
        .res (dp_res),
        .fl  (dp_fl)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = issue ? ST_VALID : ST_IDLE;
            ST_VALID: state_d = issue ? ST_VALID : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            file_we  <= 1'b0;
            wreg_we  <= 1'b0;
            flag_upd <= '0;
            flag_val <= '0;
        end else if (state_d == ST_VALID) begin
            result   <= dp_res;
            file_we  <= (ctl.dst == DST_FILE) || (ctl.dst == DST_BOTH);
            wreg_we  <= (ctl.dst == DST_WREG) || (ctl.dst == DST_BOTH);
            flag_upd <= ctl.upd;
            flag_val <= dp_fl & ctl.upd;
        end else begin
            file_we  <= 1'b0;
            wreg_we  <= 1'b0;
            flag_upd <= '0;
            flag_val <= '0;
        end
    end

    assign res_valid = (state_q == ST_VALID);
endmodule

// File: rtl/exu_chk.sv
module exu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        issue,
    input logic [15:0] instr,
    input logic        res_valid,
    input logic [7:0]  result,
    input logic        file_we,
    input logic        wreg_we,
    input logic [3:0]  flag_upd,
    input logic [3:0]  flag_val
);
    AST_VALID_TRACKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> res_valid); // R1
    AST_IDLE_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !res_valid); // R1
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!file_we && !wreg_we && flag_upd == 4'b0 && flag_val == 4'b0)); // R2
    AST_UNUPDATED_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_val & ~flag_upd) == 4'b0); // R3
    AST_Z_MATCHES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[2] |-> (flag_val[2] == (result == 8'h00))); // R3
    AST_OV_WITH_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[3] |-> (flag_upd[2:0] == 3'b111)); // R4
    AST_SET_GIVES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && instr[15:9] == 7'b0010101) |=> (result == 8'hFF && flag_upd == 4'b0)); // R8
endmodule

bind exu_top exu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .instr     (instr),
    .res_valid (res_valid),
    .result    (result),
    .file_we   (file_we),
    .wreg_we   (wreg_we),
    .flag_upd  (flag_upd),
    .flag_val  (flag_val)
);

// File: tb/exu_top_tb_top.sv
module exu_top_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] instr = '0;
    logic [7:0]  fval = '0;
    logic [7:0]  wval = '0;
    logic        c_in = 1'b0;
    logic        res_valid;
    logic [7:0]  result;
    logic        file_we, wreg_we;
    logic [3:0]  flag_upd, flag_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    exu_top dut_i (
        .clk (clk), .rst_n (rst_n), .issue (issue), .instr (instr),
        .fval (fval), .wval (wval), .c_in (c_in), .res_valid (res_valid),
        .result (result), .file_we (file_we), .wreg_we (wreg_we),
        .flag_upd (flag_upd), .flag_val (flag_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected outputs: {valid, result, file_we, wreg_we, upd, val}
    typedef struct packed {
        logic       ok;
        logic [7:0] res;
        logic       fw;
        logic       ww;
        logic [3:0] upd;
        logic [3:0] val;
    } exp_t;

    function automatic exp_t model(input logic [7:0] opc, input logic [7:0] f,
                                   input logic [7:0] w, input logic c, output string req);
        exp_t e;
        logic [6:0] code;
        logic       sb, ar, sty;
        logic [8:0] a9, b9, s9, t9;
        logic [4:0] n5;
        logic       ci, h, cy;
        code = opc[7:1]; sb = opc[0];
        e = '0; e.ok = 1'b1; ar = 1'b0; sty = 1'b0; cy = 1'b0;
        a9 = {1'b0, f}; b9 = {1'b0, w}; ci = 1'b0; req = "R11";
        case (code)
            7'b0000111: begin ar = 1; req = "R4"; end
            7'b0001000: begin ar = 1; ci = c; req = "R4"; end
            7'b0001010: begin ar = 1; b9 = 0; ci = 1; req = "R4"; end
            7'b0000010: begin ar = 1; b9 = {1'b0, ~w}; ci = 1; req = "R5"; end
            7'b0000001: begin ar = 1; b9 = {1'b0, ~w}; ci = c; req = "R5"; end
            7'b0000011: begin ar = 1; b9 = 9'h0FE; ci = 1; req = "R5"; end
            7'b0010110: begin ar = 1; a9 = 0; b9 = {1'b0, ~w}; ci = 1; sty = 1; req = "R5"; end
            7'b0000101: begin e.res = f & w; e.upd = 4'b0100; req = "R6"; end
            7'b0000100: begin e.res = f | w; e.upd = 4'b0100; req = "R6"; end
            7'b0001001: begin e.res = ~f;    e.upd = 4'b0100; req = "R6"; end
            7'b0001101: begin e.res = {f[6:0], c}; cy = f[7]; e.upd = 4'b0001; req = "R7"; end
            7'b0001100: begin e.res = {c, f[7:1]}; cy = f[0]; e.upd = 4'b0001; req = "R7"; end
            7'b0010001: begin e.res = {f[6:0], f[7]}; req = "R7"; end
            7'b0010000: begin e.res = {f[0], f[7:1]}; req = "R7"; end
            7'b0001110: begin e.res = {f[3:0], f[7:4]}; req = "R8"; end
            7'b0010101: begin e.res = 8'hFF; sty = 1; req = "R8"; end
            7'b0010100: begin e.res = 8'h00; sty = 1; req = "R8"; end
            7'b0010111: begin
                t9 = {1'b0, w} + ((w[3:0] > 9) ? 9'd6 : 9'd0);
                h  = c | t9[8] | (t9[7:4] > 9);
                e.res = t9[7:0] + (h ? 8'h60 : 8'h00);
                cy = h; e.upd = 4'b0001; sty = 1; req = "R9";
            end
            7'b0000000: begin
                if (sb) begin e.res = w; e.fw = 1; end
                return e;
            end
            default: return e;
        endcase
        if (ar) begin
            s9 = a9 + b9 + {8'b0, ci};
            n5 = {1'b0, a9[3:0]} + {1'b0, b9[3:0]} + {4'b0, ci};
            e.res = s9[7:0];
            e.upd = 4'b1111;
            e.val = {(a9[7] == b9[7]) && (s9[7] != a9[7]), s9[7:0] == 0, n5[4], s9[8]};
        end else begin
            e.val = {1'b0, e.res == 0, 1'b0, cy} & e.upd;
        end
        if (sty) begin e.fw = 1; e.ww = !sb; end
        else begin e.fw = sb; e.ww = !sb; end
        return e;
    endfunction

    task automatic check(input string req, input exp_t e);
        exp_t a;
        a = {res_valid, result, file_we, wreg_we, flag_upd, flag_val};
        n_tests++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s instr=%h f=%h w=%h c=%b actual=%h expected=%h",
                     req, instr, fval, wval, c_in, a, e);
        end
    endtask

    task automatic apply(input logic [7:0] opc, input logic [7:0] f,
                         input logic [7:0] w, input logic c);
        exp_t  e;
        string req;
        issue = 1'b1; instr = {opc, f ^ 8'h5A}; fval = f; wval = w; c_in = c;
        e = model(opc, f, w, c, req);
        @(negedge clk);
        check(req, e);
    endtask

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t z;
        string rq;
        z = '0;
        repeat (3) @(negedge clk);
        check("R2", z);                     // reset state, R2 and R1
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", z);
        // Sweep every upper byte: recognised ones densely, others sparsely (R4..R11, R10 routing)
        for (int op = 0; op < 256; op++) begin
            z = model(op[7:0], 8'h00, 8'h00, 1'b0, rq);
            if (rq == "R11" && op != 1) begin
                for (int k = 0; k < 4; k++)
                    apply(op[7:0], 8'(k * 67), 8'(k * 91 + 3), k[0]);
            end else begin
                for (int f = 0; f < 256; f += 7)
                    for (int w = 0; w < 256; w += 11)
                        for (int c = 0; c < 2; c++)
                            apply(op[7:0], f[7:0], w[7:0], c[0]);
            end
        end
        // Corner values for arithmetic flags (R4, R5)
        apply(8'h0F, 8'h7F, 8'h01, 1'b0);   // add overflow
        apply(8'h0F, 8'hFF, 8'h01, 1'b0);   // add carry, zero
        apply(8'h05, 8'h80, 8'h01, 1'b0);   // sub overflow
        apply(8'h07, 8'h00, 8'h00, 1'b0);   // dec of zero, borrow
        apply(8'h2C, 8'h00, 8'h80, 1'b0);   // negate 0x80
        apply(8'h2F, 8'h00, 8'h9A, 1'b0);   // decimal adjust R9
        // Issue gap: valid and enables drop (R1, R2)
        issue = 1'b0;
        @(negedge clk);
        z = '0;
        check("R2", z);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule